// File: doc/BRIEF.md
# Bidirectional Cascadable Column-Driver Datapath

This block is the logic core of a display column driver. A 6-bit pixel word arrives on every rising clock edge and enters six parallel 16-stage shift chains, one chain per bus bit, so that 96 column bits are held in total. A direction select reverses the shift. It also swaps the two 6-bit ports: one port takes words in and the other passes the word leaving the far end of the chains to the next device. Several devices can therefore be chained to build any line width.

A strobe-controlled latch stage captures the shifted line. While the strobe is low it follows the shift contents, and while the strobe is high it freezes. An output stage then applies two prioritised overrides and drives 96 logic-level column outputs. The output stage is written as an enumerated mode with three values. `MODE_BLANK` forces every column low. `MODE_ALL_HIGH` forces every column high. `MODE_FOLLOW` passes the latched bits through. The mode is chosen again in every cycle from the two control inputs, so there are no transitions to sequence. Any mode can follow any other.

Column numbering used below: column index `c = s*6 + k`, counted from 0. Here `s` is the chain stage (0..15) and `k` is the bus bit (0..5). Port bit `k` always feeds chain `k`.

Top module: `col_driver_core`

## Requirements
- R1: A synchronous active-low reset clears every shift stage and the latch to zero, so with `blank_n`=1 and `flood_n`=1 all 96 columns read 0 and the enabled cascade output reads 0.
- R2: With `fwd`=1, `a_in` is the data input, `b_oe`=1 and `a_oe`=0, and each rising edge moves stage s to s+1 and loads `a_in` into stage 0.
- R3: With `fwd`=0, `b_in` is the data input, `a_oe`=1 and `b_oe`=0, and each rising edge moves stage s to s-1 and loads `b_in` into stage 15.
- R4: Forward mapping: after 16 forward words from reset, the i-th word entered (i=1..16) appears on columns (16-i)*6 .. (16-i)*6+5, with bit k on column (16-i)*6+k.
- R5: Reverse mapping: after 16 reverse words, the i-th word entered appears on columns (i-1)*6 .. (i-1)*6+5, with bit k on column (i-1)*6+k.
- R6: The enabled output port carries the far-end stage (stage 15 forward, stage 0 reverse). The first word entered appears there after exactly 16 edges. The disabled port reads 0.
- R7: While `strobe`=0 the latched line equals the current shift contents, updating after every edge.
- R8: While `strobe`=1 the latched line holds the value it had when the strobe rose, even though shifting continues.
- R9: `blank_n`=0 forces all 96 columns low, whatever the strobe, `flood_n` and latched data are.
- R10: `blank_n`=1 with `flood_n`=0 forces all 96 columns high.
- R11: `blank_n`=1 with `flood_n`=1 makes each column equal its latched bit.
- R12: `a_oe` and `b_oe` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| fwd | input | 1 | 1: A in / B out, forward shift; 0: B in / A out, reverse shift |
| a_in | input | 6 | Port A input value |
| a_out | output | 6 | Port A output value (0 when not enabled) |
| a_oe | output | 1 | Port A drive enable |
| b_in | input | 6 | Port B input value |
| b_out | output | 6 | Port B output value (0 when not enabled) |
| b_oe | output | 1 | Port B drive enable |
| strobe | input | 1 | 0: latch follows shift chains; 1: latch holds |
| blank_n | input | 1 | 0 forces all columns low |
| flood_n | input | 1 | 0 (with blank_n=1) forces all columns high |
| col_out | output | 96 | Column outputs, index s*6+k |

## Verification
The bench builds two instances at the default width of 6 bits and depth of 16, with the B port of the first wired to the A port of the second. This gives one 32-stage chain per bit, and an arithmetic model tracks the words passing through it. Because both devices are in the chain, the bench can observe the cascade handoff in both directions, the exact 16-edge delay and the column mapping at both ends. Every blanking/flooding/strobe combination is swept while the data keep changing.

// File: rtl/col_drv_pkg.sv
package col_drv_pkg;
    typedef enum logic [1:0] {
        MODE_BLANK    = 2'd0,
        MODE_ALL_HIGH = 2'd1,
        MODE_FOLLOW   = 2'd2
    } drive_mode_e;
endpackage

// File: rtl/cd_shift_chain.sv
module cd_shift_chain #(
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fwd,
    input  logic             din,
    output logic [DEPTH-1:0] q,
    output logic [DEPTH-1:0] q_next,
    output logic             tail
);
    always_comb begin
        if (fwd) q_next = {q[DEPTH-2:0], din};
        else     q_next = {din, q[DEPTH-1:1]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= q_next;
    end

    assign tail = fwd ? q[DEPTH-1] : q[0];

    // R2
    fwd_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && fwd) |=> (q[0] == $past(din) && q[DEPTH-1:1] == $past(q[DEPTH-2:0])));
    // R3
    rev_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !fwd) |=> (q[DEPTH-1] == $past(din) && q[DEPTH-2:0] == $past(q[DEPTH-1:1])));
endmodule

// File: rtl/cd_line_latch.sv
module cd_line_latch #(
    parameter int NCOL = 96
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            strobe,
    input  logic [NCOL-1:0] shift_q,
    input  logic [NCOL-1:0] shift_next,
    output logic [NCOL-1:0] line
);
    logic [NCOL-1:0] held_q;

    always_ff @(posedge clk) begin
        if (!rst_n)       held_q <= '0;
        else if (!strobe) held_q <= shift_next;
    end

    assign line = strobe ? held_q : shift_q;

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && strobe) |=> (held_q == $past(held_q)));
    // R7
    track_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !strobe) |=> (held_q == shift_q));
endmodule

// File: rtl/cd_out_stage.sv
module cd_out_stage
    import col_drv_pkg::*;
#(
    parameter int NCOL = 96
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            blank_n,
    input  logic            flood_n,
    input  logic [NCOL-1:0] line,
    output logic [NCOL-1:0] col_out
);
    drive_mode_e mode;

    always_comb begin
        if (!blank_n)      mode = MODE_BLANK;
        else if (!flood_n) mode = MODE_ALL_HIGH;
        else               mode = MODE_FOLLOW;
    end

    always_comb begin
        unique case (mode)
            MODE_BLANK:    col_out = '0;
            MODE_ALL_HIGH: col_out = '1;
            MODE_FOLLOW:   col_out = line;
            default:       col_out = '0;
        endcase
    end

    // R9
    blank_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !blank_n |-> (col_out == '0));
    // R10
    flood_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_n && !flood_n) |-> (col_out == '1));
    // R11
    follow_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_n && flood_n) |-> (col_out == line));
endmodule

// File: rtl/col_driver_core.sv
module col_driver_core #(
    parameter int BUS_W = 6,
    parameter int DEPTH = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   fwd,
    input  logic [BUS_W-1:0]       a_in,
    output logic [BUS_W-1:0]       a_out,
    output logic                   a_oe,
    input  logic [BUS_W-1:0]       b_in,
    output logic [BUS_W-1:0]       b_out,
    output logic                   b_oe,
    input  logic                   strobe,
    input  logic                   blank_n,
    input  logic                   flood_n,
    output logic [BUS_W*DEPTH-1:0] col_out
);
    localparam int NCOL = BUS_W * DEPTH;

    logic [BUS_W-1:0] din;
    logic [BUS_W-1:0] tail;
    logic [NCOL-1:0]  shift_q;
    logic [NCOL-1:0]  shift_next;
    logic [NCOL-1:0]  line;

    assign din = fwd ? a_in : b_in;

    for (genvar k = 0; k < BUS_W; k++) begin : g_chain
        logic [DEPTH-1:0] cq;
        logic [DEPTH-1:0] cn;
        cd_shift_chain #(.DEPTH(DEPTH)) u_chain (
            .clk(clk), .rst_n(rst_n), .fwd(fwd), .din(din[k]),
            .q(cq), .q_next(cn), .tail(tail[k])
        );
        for (genvar s = 0; s < DEPTH; s++) begin : g_col
            assign shift_q[s*BUS_W+k]    = cq[s];
            assign shift_next[s*BUS_W+k] = cn[s];
        end
    end

    assign a_oe  = ~fwd;
    assign b_oe  = fwd;
    assign a_out = fwd ? '0 : tail;
    assign b_out = fwd ? tail : '0;

    cd_line_latch #(.NCOL(NCOL)) u_latch (
        .clk(clk), .rst_n(rst_n), .strobe(strobe),
        .shift_q(shift_q), .shift_next(shift_next), .line(line)
    );

    cd_out_stage #(.NCOL(NCOL)) u_out (
        .clk(clk), .rst_n(rst_n), .blank_n(blank_n), .flood_n(flood_n),
        .line(line), .col_out(col_out)
    );

    // R12
    oe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_oe && b_oe));
    // R6
    cascade_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_oe |-> (b_out == shift_q[NCOL-1 -: BUS_W] && a_out == '0));
    // R6
    cascade_rev_chk: assert property (@(posedge clk) disable iff (!rst_n)
        a_oe |-> (a_out == shift_q[BUS_W-1:0] && b_out == '0));
endmodule

// File: tb/sim_col_driver_core.sv
module sim_col_driver_core;
    localparam int W = 6;
    localparam int D = 16;
    localparam int N = W * D;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, fwd, strobe, blank_n, flood_n;
    logic [W-1:0] a0_in, b1_in;
    logic [W-1:0] a0_out, b0_out, a1_out, b1_out;
    logic a0_oe, b0_oe, a1_oe, b1_oe;
    logic [N-1:0] c0, c1;

    col_driver_core #(.BUS_W(W), .DEPTH(D)) u0 (
        .clk(clk), .rst_n(rst_n), .fwd(fwd),
        .a_in(a0_in), .a_out(a0_out), .a_oe(a0_oe),
        .b_in(a1_out), .b_out(b0_out), .b_oe(b0_oe),
        .strobe(strobe), .blank_n(blank_n), .flood_n(flood_n), .col_out(c0)
    );
    col_driver_core #(.BUS_W(W), .DEPTH(D)) u1 (
        .clk(clk), .rst_n(rst_n), .fwd(fwd),
        .a_in(b0_out), .a_out(a1_out), .a_oe(a1_oe),
        .b_in(b1_in), .b_out(b1_out), .b_oe(b1_oe),
        .strobe(strobe), .blank_n(blank_n), .flood_n(flood_n), .col_out(c1)
    );

    int total = 0;
    int bad = 0;
    logic [W-1:0] m   [0:2*D-1];
    logic [W-1:0] lat [0:2*D-1];
    logic [W-1:0] words [1:D];

    task automatic chk(input string tag, input logic ok, input logic [N-1:0] act, input logic [N-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [N-1:0] expect_cols(input int inst);
        logic [N-1:0] e;
        for (int s = 0; s < D; s++)
            e[s*W +: W] = strobe ? lat[inst*D+s] : m[inst*D+s];
        if (!blank_n) e = '0;
        else if (!flood_n) e = '1;
        return e;
    endfunction

    task automatic check_all();
        logic [N-1:0] e0, e1;
        string tag;
        e0 = expect_cols(0);
        e1 = expect_cols(1);
        if (!blank_n) tag = "R9";
        else if (!flood_n) tag = "R10";
        else if (strobe) tag = "R8/R11";
        else tag = "R7/R11";
        chk(tag, c0 == e0, c0, e0);
        chk(tag, c1 == e1, c1, e1);
        if (fwd)
            chk("R6 fwd cascade", b0_out == m[D-1] && b1_out == m[2*D-1] && a0_out == '0,
                N'({a0_out, b0_out, b1_out}), N'({6'd0, m[D-1], m[2*D-1]}));
        else
            chk("R6 rev cascade", a1_out == m[D] && a0_out == m[0] && b1_out == '0,
                N'({b1_out, a1_out, a0_out}), N'({6'd0, m[D], m[0]}));
        // R12 plus R2 / R3 enables
        chk(fwd ? "R2 R12 enables" : "R3 R12 enables",
            !(a0_oe && b0_oe) && b0_oe == fwd && a0_oe == !fwd && b1_oe == fwd && a1_oe == !fwd,
            N'({a0_oe, b0_oe, a1_oe, b1_oe}), N'({!fwd, fwd, !fwd, fwd}));
    endtask

    task automatic step(input logic [W-1:0] ain, input logic [W-1:0] bin);
        a0_in = ain;
        b1_in = bin;
        @(posedge clk);
        if (!rst_n) begin
            for (int s = 0; s < 2*D; s++) begin m[s] = '0; lat[s] = '0; end
        end else begin
            if (fwd) begin
                for (int s = 2*D-1; s > 0; s--) m[s] = m[s-1];
                m[0] = ain;
            end else begin
                for (int s = 0; s < 2*D-1; s++) m[s] = m[s+1];
                m[2*D-1] = bin;
            end
            if (!strobe) for (int s = 0; s < 2*D; s++) lat[s] = m[s];
        end
        @(negedge clk);
        check_all();
    endtask

    initial begin
        #1_000_000;
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [N-1:0] snap;
        logic [15:0] lf;
        rst_n = 1'b0; fwd = 1'b1; strobe = 1'b0; blank_n = 1'b1; flood_n = 1'b1;
        a0_in = '0; b1_in = '0;
        for (int s = 0; s < 2*D; s++) begin m[s] = '0; lat[s] = '0; end
        @(negedge clk);
        step(6'h3f, 6'h3f);
        step(6'h2a, 6'h15);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 reset", c0 == '0 && c1 == '0 && b0_out == '0, c0, '0);

        // R4 forward mapping, R6 16-edge delay
        for (int i = 1; i <= D; i++) begin
            words[i] = W'((i*5 + 1) & 63);
            step(words[i], 6'h0);
            if (i == D-1) chk("R6 not yet", b0_out == '0, N'(b0_out), '0);
        end
        chk("R6 first word out", b0_out == words[1], N'(b0_out), N'(words[1]));
        for (int i = 1; i <= D; i++)
            chk("R4 fwd map", c0[(D-i)*W +: W] == words[i], N'(c0[(D-i)*W +: W]), N'(words[i]));

        for (int i = 0; i < 20; i++) step(W'((i*13 + 7) & 63), 6'h0);

        // R8 hold with strobe high
        snap = c0;
        strobe = 1'b1;
        for (int i = 0; i < 10; i++) step(W'((i*11 + 5) & 63), 6'h0);
        chk("R8 hold", c0 == snap, c0, snap);
        strobe = 1'b0;
        step(6'h21, 6'h0);

        // R9 R10 R11 sweep
        for (int sb = 0; sb < 2; sb++)
            for (int bf = 0; bf < 4; bf++) begin
                strobe = sb[0]; blank_n = bf[1]; flood_n = bf[0];
                step(W'((bf*9 + sb*17 + 3) & 63), 6'h0);
                step(W'((bf*21 + 40) & 63), 6'h0);
            end
        strobe = 1'b0; blank_n = 1'b1; flood_n = 1'b1;

        // R5 reverse mapping into u1
        fwd = 1'b0;
        for (int i = 1; i <= D; i++) begin
            words[i] = W'((i*7 + 2) & 63);
            step(6'h0, words[i]);
        end
        for (int i = 1; i <= D; i++)
            chk("R5 rev map", c1[(i-1)*W +: W] == words[i], N'(c1[(i-1)*W +: W]), N'(words[i]));
        for (int i = 0; i < 20; i++) step(6'h0, W'((i*19 + 11) & 63));

        // mixed patterns with direction flips
        lf = 16'hACE1;
        for (int i = 0; i < 300; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (i % 37 == 0) fwd = ~fwd;
            strobe = (lf[3:0] == 4'h0) ? ~strobe : strobe;
            blank_n = (lf[7:4] != 4'h0);
            flood_n = (lf[11:8] != 4'h1);
            step(lf[5:0], lf[11:6]);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule